// File: doc/BRIEF.md
# Timer Capture/Compare PWM Channel

This block is one channel of a 16-bit timer. The free-running counter and its overflow strobe are shared with the rest of the timer and arrive as inputs. The channel has one pin. In capture mode the pin is an input, and a chosen edge on it copies the counter into the channel value. In the other modes the pin is an output that toggles on a compare match or forms an unbuffered PWM waveform, with a selectable active level.

Software reaches the channel through an 8-bit register bus. The 16-bit channel value is split into a high byte and a low byte. While a 16-bit read is in progress, captures are held off. While a 16-bit write is in progress, compares are held off. This keeps both byte accesses coherent.

A max-duty control can force the PWM output to its active level for whole periods. It is sampled only at counter overflow, so it starts and stops on period boundaries.

Top module: `tim_chan`

## Requirements
- R1: After reset, pin_o is 0, pin_oe_o is 0, flag_o is 0, and the control byte (address 0) reads 0x00.
- R2: Control bits [1:0] select the mode, and 00 is capture. In capture mode pin_oe_o is 0. Control bits [3:2] select the edge: 01 rising, 10 falling, 11 both. On a qualifying edge the value of cnt_i is copied into the channel value and flag_o is set. The edge is seen through a two-stage synchronizer, so the update happens on the third rising clock edge after the pin changes.
- R3: An edge that the edge field does not select causes no capture and leaves flag_o unchanged. Edge code 00 disables capture completely.
- R4: In capture mode, reading the high byte (address 2) blocks captures until the low byte (address 3) is read. Captures work again after that.
- R5: Writing the high byte stages it without changing the readback. A following low-byte write loads the full 16-bit pair, which reads back at addresses 2 and 3.
- R6: A high-byte write blocks compare events until the next low-byte write. A low-byte write with no staged high byte changes only the low readback byte. The compare keeps using the last complete pair.
- R7: Mode 01 is output compare. The pin toggles on the clock edge where cnt_i equals the channel value, and flag_o is set.
- R8: Modes 1x are PWM, with control bit 4 as the polarity and bit 5 as toggle-on-overflow. When bit 5 is 1, overflow drives the pin to the active level, which equals the polarity. A compare match drives it to the inactive level. pin_oe_o is 1.
- R9: Control bit 6 is max-duty. It is latched at overflow, and only while bit 5 is 1. Setting it forces the active level for the whole following period. Clearing it restores normal PWM from the period after the clear. With bit 5 at 0 it has no effect.
- R10: Writing the control byte with bit 7 set clears flag_o. Bit 7 reads back as flag_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Shared timer counter value |
| ovf_i | input | 1 | Counter overflow strobe, high in the cycle the counter shows its wrapped value |
| sel_i | input | 1 | Bus select |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | 2 | Register address: 0 control, 2 value high, 3 value low |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data (combinational) |
| pin_i | input | 1 | Channel pin input (capture) |
| pin_o | output | 1 | Channel pin output (compare/PWM) |
| pin_oe_o | output | 1 | Pin output enable |
| flag_o | output | 1 | Channel event flag |

## Verification
The hardest situations to reach are those where a boundary event meets an open interlock or a pending override.

Example: a second pin edge arriving while a high-byte read holds the captured value. The stimulus freezes the counter, reads the high byte, moves the counter, and toggles the pin. It then confirms that the low byte still belongs to the first capture, and that a later edge is captured normally.

For max-duty, the control byte is rewritten in the middle of a period. The bench checks that the current period is unchanged, that the next period is fully active, and that the clear takes effect only one period later. Compare blocking is shown by running a full counter period with only the high byte written.

// File: rtl/tim_chan_pkg.sv
package tim_chan_pkg;
  typedef enum logic [1:0] {
    MODE_CAP  = 2'b00,
    MODE_OC   = 2'b01,
    MODE_PWM  = 2'b10,
    MODE_PWMB = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_e;

  typedef struct packed {
    logic  max_duty;
    logic  tov;
    logic  pol;
    edge_e edg;
    mode_e mode;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd2;
  localparam logic [1:0] ADDR_LO   = 2'd3;
endpackage

// File: rtl/tim_chan_edge.sv
module tim_chan_edge
  import tim_chan_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_i,
  input  edge_e edg_i,
  output logic  stb_o
);
  logic sync_s;
  logic prev_q;

  generate
    if (SYNC_N > 1) begin : g_chain
      logic [SYNC_N-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_N-2:0], pin_i};
      end
      assign sync_s = sync_q[SYNC_N-1];
    end else begin : g_single
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= pin_i;
      end
      assign sync_s = sync_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_s;
  end

  logic rise, fall;
  assign rise = sync_s & ~prev_q;
  assign fall = ~sync_s & prev_q;

  always_comb begin
    unique case (edg_i)
      EDGE_RISE: stb_o = rise;
      EDGE_FALL: stb_o = fall;
      EDGE_ANY:  stb_o = rise | fall;
      default:   stb_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tim_chan_regs.sv
module tim_chan_regs #(
  parameter int BUS_W = 8,
  localparam int VAL_W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic             rd_hi_i,
  input  logic             rd_lo_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             cap_mode_i,
  input  logic             cap_stb_i,
  input  logic [VAL_W-1:0] cap_val_i,
  output logic [VAL_W-1:0] val_o,
  output logic [VAL_W-1:0] cmp_o,
  output logic             cap_lock_o,
  output logic             cmp_lock_o,
  output logic             cap_evt_o
);
  logic [BUS_W-1:0] hi_q;
  logic [VAL_W-1:0] val_q, cmp_q;
  logic             cap_lock_q, wr_pend_q;

  assign cap_evt_o = cap_stb_i & cap_mode_i & ~cap_lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_lock_q <= 1'b0;
      wr_pend_q  <= 1'b0;
    end else begin
      if (rd_lo_i)                   cap_lock_q <= 1'b0;
      else if (rd_hi_i && cap_mode_i) cap_lock_q <= 1'b1;
      if (wr_lo_i)      wr_pend_q <= 1'b0;
      else if (wr_hi_i) wr_pend_q <= 1'b1;
    end
  end

  // value registers have no defined reset state
  always_ff @(posedge clk_i) begin
    if (wr_hi_i) hi_q <= wdata_i;
    if (wr_lo_i) begin
      if (wr_pend_q) begin
        val_q <= {hi_q, wdata_i};
        cmp_q <= {hi_q, wdata_i};
      end else begin
        val_q[BUS_W-1:0] <= wdata_i;
      end
    end else if (cap_evt_o) begin
      val_q <= cap_val_i;
    end
  end

  assign val_o      = val_q;
  assign cmp_o      = cmp_q;
  assign cap_lock_o = cap_lock_q;
  assign cmp_lock_o = wr_pend_q;
endmodule

// File: rtl/tim_chan_out.sv
module tim_chan_out
  import tim_chan_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  pol_i,
  input  logic  tov_i,
  input  logic  max_i,
  input  logic  ovf_i,
  input  logic  match_i,
  output logic  pin_o,
  output logic  max_eff_o,
  output logic  cmp_evt_o
);
  logic pin_q, max_q;

  assign cmp_evt_o = match_i & (mode_i != MODE_CAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      max_q <= 1'b0;
    end else begin
      if (ovf_i) max_q <= max_i & tov_i;
      unique case (mode_i)
        MODE_CAP: pin_q <= pin_q;
        MODE_OC:  if (match_i) pin_q <= ~pin_q;
        default: begin
          if (ovf_i && tov_i) pin_q <= pol_i;
          else if (max_q)     pin_q <= pol_i;
          else if (match_i)   pin_q <= ~pol_i;
        end
      endcase
    end
  end

  assign pin_o     = pin_q;
  assign max_eff_o = max_q;
endmodule

// File: rtl/tim_chan.sv
module tim_chan
  import tim_chan_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int SYNC_N = 2,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_i,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             flag_o
);
  ctrl_t            ctrl_q;
  logic             flag_q;
  logic             bus_wr, bus_rd, ctrl_wr, flag_clr;
  logic             cap_stb, cap_evt, cmp_evt, match;
  logic             cap_lock, cmp_lock, max_eff;
  logic [CNT_W-1:0] val, cmp;

  assign bus_wr   = sel_i & wr_i;
  assign bus_rd   = sel_i & rd_i;
  assign ctrl_wr  = bus_wr && (addr_i == ADDR_CTRL);
  assign flag_clr = ctrl_wr && wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[6:0]);
      if (cap_evt || cmp_evt) flag_q <= 1'b1;
      else if (flag_clr)      flag_q <= 1'b0;
    end
  end

  tim_chan_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .edg_i  (ctrl_q.edg),
    .stb_o  (cap_stb)
  );

  tim_chan_regs #(.BUS_W(BUS_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_hi_i    (bus_wr && (addr_i == ADDR_HI)),
    .wr_lo_i    (bus_wr && (addr_i == ADDR_LO)),
    .rd_hi_i    (bus_rd && (addr_i == ADDR_HI)),
    .rd_lo_i    (bus_rd && (addr_i == ADDR_LO)),
    .wdata_i    (wdata_i),
    .cap_mode_i (ctrl_q.mode == MODE_CAP),
    .cap_stb_i  (cap_stb),
    .cap_val_i  (cnt_i),
    .val_o      (val),
    .cmp_o      (cmp),
    .cap_lock_o (cap_lock),
    .cmp_lock_o (cmp_lock),
    .cap_evt_o  (cap_evt)
  );

  assign match = (cnt_i == cmp) & ~cmp_lock;

  tim_chan_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (ctrl_q.mode),
    .pol_i     (ctrl_q.pol),
    .tov_i     (ctrl_q.tov),
    .max_i     (ctrl_q.max_duty),
    .ovf_i     (ovf_i),
    .match_i   (match),
    .pin_o     (pin_o),
    .max_eff_o (max_eff),
    .cmp_evt_o (cmp_evt)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = BUS_W'({flag_q, ctrl_q});
      ADDR_HI:   rdata_o = val[CNT_W-1:BUS_W];
      ADDR_LO:   rdata_o = val[BUS_W-1:0];
      default:   rdata_o = '0;
    endcase
  end

  assign pin_oe_o = (ctrl_q.mode != MODE_CAP);
  assign flag_o   = flag_q;
endmodule

// File: rtl/tim_chan_chk.sv
module tim_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ovf_i,
  input logic             bus_wr,
  input logic             pwm_mode,
  input logic             oc_mode,
  input logic             pol,
  input logic             max_eff,
  input logic             cap_lock,
  input logic             cmp_lock,
  input logic [CNT_W-1:0] val,
  input logic             pin_o,
  input logic             flag_o,
  input logic             flag_clr,
  input logic             set_evt
);
  // R4
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_lock && !bus_wr |=> $stable(val));

  // R9
  max_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_mode && max_eff |=> pin_o == $past(pol));

  // R9
  max_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_i |=> $stable(max_eff));

  // R6
  cmp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_mode && cmp_lock |=> $stable(pin_o));

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> flag_o);

  // R10
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr && !set_evt |=> !flag_o);
endmodule

bind tim_chan tim_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ovf_i    (ovf_i),
  .bus_wr   (bus_wr),
  .pwm_mode (ctrl_q.mode[1]),
  .oc_mode  (ctrl_q.mode == tim_chan_pkg::MODE_OC),
  .pol      (ctrl_q.pol),
  .max_eff  (max_eff),
  .cap_lock (cap_lock),
  .cmp_lock (cmp_lock),
  .val      (val),
  .pin_o    (pin_o),
  .flag_o   (flag_o),
  .flag_clr (flag_clr),
  .set_evt  (cap_evt | cmp_evt)
);

// File: tb/tim_chan_tb.sv
module tim_chan_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] cnt_i;
  logic        ovf_i, sel_i, wr_i, rd_i, pin_i;
  logic [1:0]  addr_i;
  logic [7:0]  wdata_i, rdata_o;
  logic        pin_o, pin_oe_o, flag_o;

  always #2 clk_i = ~clk_i;

  tim_chan u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_i), .ovf_i(ovf_i),
    .sel_i(sel_i), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .flag_o(flag_o)
  );

  // scoreboard
  string req_q[$];
  int    exp_q[$];
  int    act_q[$];
  int    n_push = 0, n_pop = 0;
  int    total = 0, bad = 0;
  bit    done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    req_q.push_back(req);
    exp_q.push_back(exp);
    act_q.push_back(act);
    n_push++;
  endtask

  initial begin
    forever begin
      wait (n_push > n_pop);
      begin
        string r;
        int    a, e;
        r = req_q.pop_front();
        a = act_q.pop_front();
        e = exp_q.pop_front();
        n_pop++;
        total++;
        if (a != e) begin
          bad++;
          $display("FAIL %s act=%0h exp=%0h", r, a, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    sel_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    bus_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pin_edge(input logic lvl);
    @(negedge clk_i);
    pin_i = lvl;
    repeat (4) @(negedge clk_i);
  endtask

  // one counter period; pin expected lv_a while c<cv, lv_b afterwards
  task automatic run_period(input int per, input int cv, input bit lv_a, input bit lv_b,
                            input int wr_at, input logic [7:0] wr_d, input string req);
    bit pend_v = 1'b0;
    bit pend_e = 1'b0;
    for (int c = 0; c < per; c++) begin
      @(negedge clk_i);
      if (pend_v) check(req, pin_o, pend_e);
      sel_i = 1'b0; wr_i = 1'b0;
      cnt_i = 16'(c);
      ovf_i = (c == 0);
      pend_e = (c < cv) ? lv_a : lv_b;
      pend_v = 1'b1;
      if (c == wr_at) begin
        sel_i = 1'b1; wr_i = 1'b1; addr_i = 2'd0; wdata_i = wr_d;
      end
    end
    @(negedge clk_i);
    check(req, pin_o, pend_e);
    sel_i = 1'b0; wr_i = 1'b0; ovf_i = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    rst_ni = 1'b0; cnt_i = '0; ovf_i = 1'b0; sel_i = 1'b0; wr_i = 1'b0;
    rd_i = 1'b0; addr_i = '0; wdata_i = '0; pin_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    check("R1 pin_o", pin_o, 0);
    check("R1 pin_oe_o", pin_oe_o, 0);
    check("R1 flag_o", flag_o, 0);
    bus_rd(2'd0, d);
    check("R1 ctrl", d, 0);

    // R2 rising edge capture
    bus_wr(2'd0, 8'h04);
    cnt_i = 16'h1234;
    pin_edge(1'b1);
    check("R2 flag", flag_o, 1);
    check("R2 pin_oe_o", pin_oe_o, 0);
    rd_chk(2'd2, 8'h12, "R2 hi");
    rd_chk(2'd3, 8'h34, "R2 lo");
    bus_wr(2'd0, 8'h84);
    check("R10 flag clear", flag_o, 0);

    // R3 unselected edge and disabled capture
    cnt_i = 16'h5555;
    pin_edge(1'b0);
    check("R3 falling ignored flag", flag_o, 0);
    rd_chk(2'd2, 8'h12, "R3 hi");
    rd_chk(2'd3, 8'h34, "R3 lo");
    bus_wr(2'd0, 8'h00);
    pin_edge(1'b1);
    check("R3 edge off flag", flag_o, 0);
    rd_chk(2'd3, 8'h34, "R3 edge off lo");

    // R4 read interlock with both edges selected
    bus_wr(2'd0, 8'h0C);
    cnt_i = 16'hA0B1;
    pin_edge(1'b0);
    rd_chk(2'd2, 8'hA0, "R4 hi");
    cnt_i = 16'hC0D2;
    pin_edge(1'b1);
    rd_chk(2'd3, 8'hB1, "R4 lo coherent");
    rd_chk(2'd2, 8'hA0, "R4 hi unchanged");
    rd_chk(2'd3, 8'hB1, "R4 lo unchanged");
    pin_edge(1'b0);
    rd_chk(2'd2, 8'hC0, "R4 hi after release");
    rd_chk(2'd3, 8'hD2, "R4 lo after release");

    // R5 paired write, PWM mode pol=1 tov=1
    cnt_i = 16'd15;
    bus_wr(2'd0, 8'h32);
    check("R8 pin_oe_o", pin_oe_o, 1);
    bus_wr(2'd2, 8'h00);
    rd_chk(2'd2, 8'hC0, "R5 hi staged only");
    bus_wr(2'd3, 8'h05);
    rd_chk(2'd2, 8'h00, "R5 hi");
    rd_chk(2'd3, 8'h05, "R5 lo");

    // R8 PWM both polarities
    run_period(16, 5, 1'b1, 1'b0, -1, 8'h00, "R8 pol1");
    run_period(16, 5, 1'b1, 1'b0, -1, 8'h00, "R8 pol1");
    bus_wr(2'd0, 8'h22);
    run_period(16, 5, 1'b0, 1'b1, -1, 8'h00, "R8 pol0");

    // R9 max-duty latency
    bus_wr(2'd0, 8'h32);
    run_period(16, 5, 1'b1, 1'b0, 8, 8'h72, "R9 set period");
    run_period(16, 5, 1'b1, 1'b1, 8, 8'h32, "R9 forced period");
    run_period(16, 5, 1'b1, 1'b0, -1, 8'h00, "R9 after clear");
    bus_wr(2'd0, 8'h52);
    run_period(16, 5, 1'b0, 1'b0, -1, 8'h00, "R9 no tov");

    // R7 output compare toggle
    bus_wr(2'd0, 8'h81);
    check("R10 flag clear oc", flag_o, 0);
    run_period(16, 5, 1'b0, 1'b1, -1, 8'h00, "R7 toggle");
    check("R7 flag", flag_o, 1);

    // R6 write interlock
    bus_wr(2'd2, 8'h00);
    run_period(16, 5, 1'b1, 1'b1, -1, 8'h00, "R6 blocked");
    bus_wr(2'd3, 8'h09);
    run_period(16, 9, 1'b1, 1'b0, -1, 8'h00, "R6 new pair");
    bus_wr(2'd3, 8'h03);
    rd_chk(2'd3, 8'h03, "R6 lo only");
    rd_chk(2'd2, 8'h00, "R6 hi kept");
    run_period(16, 9, 1'b0, 1'b1, -1, 8'h00, "R6 old pair used");

    wait (n_pop == n_push);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule